// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular receive area of a packet buffer RAM that is divided into 256-byte pages. The area runs from a start page up to, but not including, a stop page. Each frame is placed at the current page. The first four bytes of that page are kept free for a link header, and data begins at offset 4. Data addresses step forward one byte at a time. When they leave page stop-1, they continue at the start page, so a frame may cross the wrap point.

After the last byte of a frame, the block writes the four header bytes in this order:

1. the receive status;
2. the page where the next frame will go;
3. the low byte of the frame length;
4. the high byte of the frame length.

The current pointer then moves to that next page. A boundary pointer marks the oldest page that the host has not yet consumed. If a frame would write into the boundary page, the frame is abandoned and a sticky overflow flag is raised. Frames are dropped until the host clears the flag.

The host reaches the pointers through a small register port. One write code releases consumed space: it places the boundary one page below the page of the next unread frame, wrapping to stop-1 when needed.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the register port reads start = 0x40 (select 0), stop = 0x80 (select 1), current = 0x41 (select 2) and boundary = 0x40 (select 3 or 4). The overflow flag is 0 and rx_ready is 1.
- R2: The first data byte of a frame is written at address {current, 0x04}. Each following accepted byte is written at the next address, with ram_wdata equal to rx_data.
- R3: After the byte at offset 0xFF of page stop-1, the next data byte is written at {start, 0x00}.
- R4: After the cycle that accepts the byte with rx_last, four writes follow in four consecutive cycles, and rx_ready is 0 during them. The writes go to {current, 0x00..0x03} and carry the rx_status captured with the last byte, the next page, the length low byte and the length high byte. The length is the number of data bytes.
- R5: The next page is the page after the one holding the frame's last data byte. If that page equals stop, the start page is used instead. Current takes this value in the cycle rx_ready returns to 1.
- R6: A data byte whose address lies in the boundary page is not written and sets the overflow flag. The remaining bytes of that frame are ignored, no header is written, and current is unchanged.
- R7: While the overflow flag is 1, every byte is ignored and nothing is written. A cycle with ovf_clr = 1 clears the flag, and the next frame is then stored normally.
- R8: A register write with select 4 and value P sets boundary to P-1. If P <= start, boundary is set to stop-1 instead.
- R9: Register writes with selects 0..3 load start, stop, current and boundary, and reg_rdata returns the selected register in the same cycle.
- R10: If an overflow is detected in the same cycle as ovf_clr = 1, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_status | input | 8 | Receive status, sampled with the last byte |
| rx_ready | output | 1 | Byte accepted when high (low while the header is written) |
| ram_we | output | 1 | Buffer RAM write strobe |
| ram_addr | output | 16 | Buffer RAM byte address {page, offset} |
| ram_wdata | output | 8 | Buffer RAM write data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 start, 1 stop, 2 current, 3 boundary, 4 release to page |
| reg_wdata | input | 8 | Register write value (a page number) |
| reg_rdata | output | 8 | Selected register value |
| ovf_clr | input | 1 | Write one to clear the overflow flag |
| ovf_flag | output | 1 | Sticky ring-full flag |

## Verification
The assertions assume that start is below stop, and that the host changes start, stop and current only between frames. They also assume that rx_valid is raised only while rx_ready is high, so no byte is offered during a header. The directed tasks program the pointers only while the ring is idle. Each task waits for rx_ready to return before it offers the next frame, and every value it writes keeps start < stop with current inside the ring.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_HDR  = 2'd3
    } ring_fsm_t;

    localparam int OFS_W     = 8;
    localparam int HDR_BYTES = 4;
    localparam int BEAT_W    = $clog2(HDR_BYTES);

    localparam logic [2:0] SEL_START = 3'd0;
    localparam logic [2:0] SEL_STOP  = 3'd1;
    localparam logic [2:0] SEL_CURR  = 3'd2;
    localparam logic [2:0] SEL_BND   = 3'd3;
    localparam logic [2:0] SEL_FREE  = 3'd4;

endpackage

// File: rtl/rx_ring_step.sv
module rx_ring_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W+rx_ring_pkg::OFS_W-1:0] addr,
    input  logic [PAGE_W-1:0]                    start_pg,
    input  logic [PAGE_W-1:0]                    stop_pg,
    output logic [PAGE_W+rx_ring_pkg::OFS_W-1:0] addr_next,
    output logic [PAGE_W-1:0]                    page_after
);
    import rx_ring_pkg::*;

    logic [PAGE_W-1:0] page_cur;
    logic [PAGE_W-1:0] page_inc;
    logic [OFS_W-1:0]  ofs_cur;

    always_comb begin
        page_cur = addr[PAGE_W+OFS_W-1:OFS_W];
        ofs_cur  = addr[OFS_W-1:0];
        page_inc = page_cur + 1'b1;
        if (page_inc == stop_pg) begin
            page_inc = start_pg;
        end
        page_after = page_inc;
        if (ofs_cur == {OFS_W{1'b1}}) begin
            addr_next = {page_inc, {OFS_W{1'b0}}};
        end else begin
            addr_next = {page_cur, ofs_cur + 1'b1};
        end
    end

endmodule

// File: rtl/rx_ring_hdr.sv
module rx_ring_hdr #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [rx_ring_pkg::BEAT_W-1:0] beat,
    input  logic [7:0]                     status,
    input  logic [PAGE_W-1:0]              next_pg,
    input  logic [LEN_W-1:0]               length,
    output logic [7:0]                     hdr_byte
);
    import rx_ring_pkg::*;

    localparam int LEN_BYTES = HDR_BYTES - 2;

    logic [7:0] slot [HDR_BYTES];
    logic [8*LEN_BYTES-1:0] len_ext;

    assign len_ext = (8*LEN_BYTES)'(length);
    assign slot[0] = status;
    assign slot[1] = 8'(next_pg);

    for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len
        assign slot[2+g] = len_ext[8*g +: 8];
    end

    assign hdr_byte = slot[beat];

endmodule

// File: rtl/rx_ring_free.sv
module rx_ring_free #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] next_unread,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic [PAGE_W-1:0] bnd_new
);
    always_comb begin
        if (next_unread <= start_pg) begin
            bnd_new = stop_pg - 1'b1;
        end else begin
            bnd_new = next_unread - 1'b1;
        end
    end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
    parameter int              PAGE_W    = 8,
    parameter int              LEN_W     = 16,
    parameter logic [PAGE_W-1:0] RST_START = 8'h40,
    parameter logic [PAGE_W-1:0] RST_STOP  = 8'h80
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    input  logic                       rx_last,
    input  logic [7:0]                 rx_status,
    output logic                       rx_ready,
    output logic                       ram_we,
    output logic [PAGE_W+8-1:0]        ram_addr,
    output logic [7:0]                 ram_wdata,
    input  logic                       reg_we,
    input  logic [2:0]                 reg_sel,
    input  logic [PAGE_W-1:0]          reg_wdata,
    output logic [PAGE_W-1:0]          reg_rdata,
    input  logic                       ovf_clr,
    output logic                       ovf_flag
);
    import rx_ring_pkg::*;

    localparam int ADDR_W = PAGE_W + OFS_W;
    localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(HDR_BYTES);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(HDR_BYTES - 1);

    typedef struct packed {
        ring_fsm_t         fsm;
        logic [ADDR_W-1:0] wr;
        logic [LEN_W-1:0]  len;
        logic [PAGE_W-1:0] nxt;
        logic [7:0]        stat;
        logic [BEAT_W-1:0] beat;
        logic [PAGE_W-1:0] start;
        logic [PAGE_W-1:0] stop;
        logic [PAGE_W-1:0] curr;
        logic [PAGE_W-1:0] bnd;
        logic              ovf;
    } ring_state_t;

    ring_state_t st_d, st_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] step_addr;
    logic [PAGE_W-1:0] step_page;
    logic [7:0]        hdr_byte;
    logic [PAGE_W-1:0] bnd_free;
    logic              accept;
    logic              full;
    logic              ready_w;

    assign cur_addr = (st_q.fsm == ST_IDLE) ? {st_q.curr, DATA_OFS} : st_q.wr;
    assign ready_w  = (st_q.fsm != ST_HDR);
    assign accept   = rx_valid && ready_w;
    assign full     = (cur_addr[ADDR_W-1:OFS_W] == st_q.bnd);

    rx_ring_step #(.PAGE_W(PAGE_W)) u_step (
        .addr       (cur_addr),
        .start_pg   (st_q.start),
        .stop_pg    (st_q.stop),
        .addr_next  (step_addr),
        .page_after (step_page)
    );

    rx_ring_hdr #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_hdr (
        .beat     (st_q.beat),
        .status   (st_q.stat),
        .next_pg  (st_q.nxt),
        .length   (st_q.len),
        .hdr_byte (hdr_byte)
    );

    rx_ring_free #(.PAGE_W(PAGE_W)) u_free (
        .next_unread (reg_wdata),
        .start_pg    (st_q.start),
        .stop_pg     (st_q.stop),
        .bnd_new     (bnd_free)
    );

    always_comb begin
        st_d      = st_q;
        ram_we    = 1'b0;
        ram_addr  = cur_addr;
        ram_wdata = rx_data;

        if (reg_we) begin
            case (reg_sel)
                SEL_START: st_d.start = reg_wdata;
                SEL_STOP:  st_d.stop  = reg_wdata;
                SEL_CURR:  st_d.curr  = reg_wdata;
                SEL_BND:   st_d.bnd   = reg_wdata;
                SEL_FREE:  st_d.bnd   = bnd_free;
                default:   ;
            endcase
        end

        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end

        case (st_q.fsm)
            ST_IDLE, ST_RECV: begin
                if (accept) begin
                    if (st_q.ovf) begin
                        st_d.fsm = rx_last ? ST_IDLE : ST_DROP;
                    end else if (full) begin
                        st_d.ovf = 1'b1;
                        st_d.fsm = rx_last ? ST_IDLE : ST_DROP;
                    end else begin
                        ram_we  = 1'b1;
                        st_d.wr = step_addr;
                        st_d.len = (st_q.fsm == ST_IDLE) ? LEN_W'(1) : st_q.len + 1'b1;
                        if (rx_last) begin
                            st_d.stat = rx_status;
                            st_d.nxt  = step_page;
                            st_d.beat = '0;
                            st_d.fsm  = ST_HDR;
                        end else begin
                            st_d.fsm  = ST_RECV;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (accept && rx_last) begin
                    st_d.fsm = ST_IDLE;
                end
            end
            ST_HDR: begin
                ram_we    = 1'b1;
                ram_addr  = {st_q.curr, OFS_W'(st_q.beat)};
                ram_wdata = hdr_byte;
                st_d.beat = st_q.beat + 1'b1;
                if (st_q.beat == LAST_BEAT) begin
                    st_d.curr = st_q.nxt;
                    st_d.fsm  = ST_IDLE;
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fsm   <= ST_IDLE;
            st_q.start <= RST_START;
            st_q.stop  <= RST_STOP;
            st_q.curr  <= RST_START + 1'b1;
            st_q.bnd   <= RST_START;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_START: reg_rdata = st_q.start;
            SEL_STOP:  reg_rdata = st_q.stop;
            SEL_CURR:  reg_rdata = st_q.curr;
            default:   reg_rdata = st_q.bnd;
        endcase
    end

    assign rx_ready = ready_w;
    assign ovf_flag = st_q.ovf;

    logic [PAGE_W-1:0] curr_w;
    logic [PAGE_W-1:0] bnd_w;
    assign curr_w = st_q.curr;
    assign bnd_w  = st_q.bnd;

endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              ram_we,
    input logic [PAGE_W+7:0] ram_addr,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              ovf_flag,
    input logic [PAGE_W-1:0] curr_w,
    input logic [PAGE_W-1:0] bnd_w
);
    // R6
    bnd_page_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && rx_ready) |-> (ram_addr[PAGE_W+7:8] != bnd_w));

    // R4
    hdr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (ram_we && (ram_addr[7:0] < 8'd4) && (ram_addr[PAGE_W+7:8] == curr_w)));

    // R5
    curr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(curr_w) |-> ($rose(rx_ready) || $past(reg_we && (reg_sel == 3'd2))));

    // R7
    ovf_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> !ram_we);

    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(rx_valid && rx_ready));

endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .ovf_flag (ovf_flag),
    .curr_w   (curr_w),
    .bnd_w    (bnd_w)
);

// File: tb/rx_ring_mgr_test.sv
`timescale 1ns/1ps
module rx_ring_mgr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [7:0]  rx_status = '0;
    logic        rx_ready;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ovf_clr = 1'b0;
    logic        ovf_flag;

    int vectors = 0;
    int misses  = 0;
    int wcount  = 0;
    logic [7:0] mem [int];

    always #2.5 clk = ~clk;

    rx_ring_mgr uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_status(rx_status), .rx_ready(rx_ready),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        if (rst_n && ram_we) begin
            mem[int'(ram_addr)] = ram_wdata;
            wcount++;
        end
    end

    task automatic check(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int rd_mem(int a);
        if (mem.exists(a)) return int'(mem[a]);
        return -1;
    endfunction

    task automatic reg_rd(logic [2:0] sel, output int v);
        @(negedge clk);
        reg_sel = sel;
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic reg_wr(logic [2:0] sel, logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send_frame(int n, logic [7:0] seed, logic [7:0] stat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = seed + 8'(i);
            rx_last = (i == n - 1); rx_status = stat;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        reg_rd(3'd0, v); check("R1 start", v, 'h40);
        reg_rd(3'd1, v); check("R1 stop", v, 'h80);
        reg_rd(3'd2, v); check("R1 curr", v, 'h41);
        reg_rd(3'd3, v); check("R1 bnd", v, 'h40);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 ready", int'(rx_ready), 1);
    endtask

    task automatic t_basic();
        int v; int w0;
        w0 = wcount;
        send_frame(10, 8'h10, 8'hA1);
        check("R2 first byte", rd_mem('h4104), 'h10);
        check("R2 last byte", rd_mem('h410D), 'h19);
        check("R4 status", rd_mem('h4100), 'hA1);
        check("R4 next", rd_mem('h4101), 'h42);
        check("R4 len lo", rd_mem('h4102), 10);
        check("R4 len hi", rd_mem('h4103), 0);
        check("R4 write count", wcount - w0, 14);
        reg_rd(3'd2, v); check("R5 curr", v, 'h42);
    endtask

    task automatic t_full_page();
        int v;
        send_frame(252, 8'h00, 8'h01);
        check("R2 page end byte", rd_mem('h42FF), 251);
        check("R5 next exact page", rd_mem('h4201), 'h43);
        reg_rd(3'd2, v); check("R5 curr exact page", v, 'h43);
    endtask

    task automatic t_wrap();
        int v;
        reg_wr(3'd2, 8'h7F);
        reg_wr(3'd3, 8'h50);
        reg_rd(3'd2, v); check("R9 curr write", v, 'h7F);
        reg_rd(3'd3, v); check("R9 bnd write", v, 'h50);
        send_frame(300, 8'h00, 8'h21);
        check("R3 before wrap", rd_mem('h7FFF), 251);
        check("R3 after wrap", rd_mem('h4000), 252 & 'hFF);
        check("R3 tail", rd_mem('h402F), 299 & 'hFF);
        check("R5 wrapped next", rd_mem('h7F01), 'h41);
        check("R4 len lo 300", rd_mem('h7F02), 300 & 'hFF);
        check("R4 len hi 300", rd_mem('h7F03), 1);
        reg_rd(3'd2, v); check("R5 curr wrapped", v, 'h41);
    endtask

    task automatic t_overflow();
        int v; int w0;
        reg_wr(3'd3, 8'h42);
        mem.delete('h4100);
        w0 = wcount;
        send_frame(300, 8'h55, 8'h33);
        check("R6 writes before full", wcount - w0, 252);
        check("R6 ovf set", int'(ovf_flag), 1);
        check("R6 no header", int'(mem.exists('h4100)), 0);
        reg_rd(3'd2, v); check("R6 curr kept", v, 'h41);
    endtask

    task automatic t_sticky();
        int v; int w0;
        reg_wr(3'd3, 8'h60);
        w0 = wcount;
        send_frame(5, 8'h77, 8'h44);
        check("R7 dropped while set", wcount - w0, 0);
        check("R7 still set", int'(ovf_flag), 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check("R7 cleared", int'(ovf_flag), 0);
        w0 = wcount;
        send_frame(5, 8'h90, 8'h45);
        check("R7 resumed data", rd_mem('h4104), 'h90);
        check("R7 resumed next", rd_mem('h4101), 'h42);
        check("R7 resumed count", wcount - w0, 9);
        reg_rd(3'd2, v); check("R7 curr moved", v, 'h42);
    endtask

    task automatic t_set_wins();
        int w0;
        reg_wr(3'd3, 8'h42);
        w0 = wcount;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; ovf_clr = 1'b0;
        check("R10 set wins", int'(ovf_flag), 1);
        check("R10 no write", wcount - w0, 0);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check("R10 later clear", int'(ovf_flag), 0);
    endtask

    task automatic t_release();
        int v;
        reg_wr(3'd4, 8'h55);
        reg_rd(3'd3, v); check("R8 release mid", v, 'h54);
        reg_wr(3'd4, 8'h40);
        reg_rd(3'd3, v); check("R8 release at start", v, 'h7F);
        reg_wr(3'd4, 8'h41);
        reg_rd(3'd3, v); check("R8 release above start", v, 'h40);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_full_page();
        t_wrap();
        t_overflow();
        t_sticky();
        t_set_wins();
        t_release();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule